// File: doc/BRIEF.md
# Memory-Domain Association Table with Column Locks

This block holds, for each requester, a bit vector that says which memory domains the requester belongs to. There are up to 63 domains. Software reads and writes the table through a simple word-wide register bus. Two lock registers provide one lock bit per domain. Setting a domain's lock bit freezes that domain's column in every requester row. A sticky master lock bit then freezes the lock registers themselves, so the configuration cannot be changed again until reset.

A combinational lookup port takes a requester index and returns that requester's association vector, which the permission logic downstream uses. A build parameter selects a variant without locking. In that variant the lock registers read as zero and all table bits stay writable.

Top module: `md_assoc_lock`

## Requirements
- R1: After reset, every association bit, every domain lock bit and the master lock read as zero.
- R2: Word address 2+2s holds domains 0..31 of requester s in bits 31:0. Word address 3+2s holds domains 32..62 in bits 30:0. Bit 31 of the high word always reads zero. A write replaces the unlocked bits of the addressed word.
- R3: At word address 0, bit 0 is the master lock and bits 31:1 lock domains 0..30. At word address 1, bits 31:0 lock domains 31..62.
- R4: A table write leaves every bit position whose domain is locked at its old value. The write still updates the unlocked positions of the same word.
- R5: A 1 written to a lock bit sets it. Writing 0 leaves the bit unchanged, and only reset clears it.
- R6: Once the master lock is 1, it stays 1, and writes to both lock registers are ignored.
- R7: The lookup port returns, in the same cycle, the association vector of the presented requester index. An index of NUM_REQ or above returns all zeros.
- R8: Writes to word addresses 2+2*NUM_REQ and above are ignored, and reads of those addresses return zero.
- R9: With LOCK_EN=0, lock register writes have no effect, both lock registers read zero, and every table bit stays writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| lookup_idx_i | input | IDX_W | Requester index to look up |
| lookup_md_o | output | NUM_MD | Association vector of the indexed requester |

## Verification
A lock bit that is stored wrongly first shows up on the next read of the lock word. Its effect on behaviour shows up one cycle after the next table write to that column, when a bit that should have been held changes, or a bit that should have changed is held. That change is visible on both the read port and the lookup port. A master lock that fails to stick shows up one cycle after the following lock write, as a changed lock word. A lookup mux that selects the wrong row shows up immediately, because the lookup output is compared with an independent model on every random index, including indices out of range.

// File: rtl/md_lock_pkg.sv
package md_lock_pkg;
  localparam int MD_SPACE   = 64;
  localparam int WORD_W     = 32;
  localparam int LOCK_LO_A  = 0;
  localparam int LOCK_HI_A  = 1;
  localparam int ENTRY_BASE = 2;

  function automatic logic [MD_SPACE-1:0] md_valid_mask(input int n);
    return (64'd1 << n) - 64'd1;
  endfunction
endpackage

// File: rtl/md_lock_regs.sv
module md_lock_regs
  import md_lock_pkg::*;
#(
  parameter int NUM_MD  = 63,
  parameter bit LOCK_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [MD_SPACE-1:0] lock_o,
  output logic [WORD_W-1:0]   rd_lo_o,
  output logic [WORD_W-1:0]   rd_hi_o
);
  localparam logic [MD_SPACE-1:0] VALID = md_valid_mask(NUM_MD);

  logic                master_q;
  logic [MD_SPACE-1:0] lock_q;
  logic [MD_SPACE-1:0] set_bits;

  always_comb begin
    set_bits = '0;
    if (wr_lo_i) set_bits = {33'd0, wdata_i[31:1]};
    if (wr_hi_i) set_bits = {1'b0, wdata_i, 31'd0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      lock_q   <= '0;
    end else if (LOCK_EN && !master_q) begin
      lock_q <= lock_q | (set_bits & VALID);
      if (wr_lo_i) master_q <= master_q | wdata_i[0];
    end
  end

  assign lock_o  = lock_q;
  assign rd_lo_o = {lock_q[30:0], master_q};
  assign rd_hi_o = lock_q[62:31];

  assert_master_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_q |=> master_q);
  assert_locks_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_q |=> $stable(lock_q));
  assert_lock_no_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i || wr_hi_i) |=> (($past(lock_q) & ~lock_q) == '0));
  assert_nolock_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !LOCK_EN |-> (rd_lo_o == '0 && rd_hi_o == '0));
endmodule

// File: rtl/md_assoc_row.sv
module md_assoc_row
  import md_lock_pkg::*;
#(
  parameter int NUM_MD = 63
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [MD_SPACE-1:0] lock_i,
  output logic [MD_SPACE-1:0] assoc_o
);
  localparam logic [MD_SPACE-1:0] VALID = md_valid_mask(NUM_MD);

  logic [MD_SPACE-1:0] assoc_q, upd, sel, wen;

  always_comb begin
    upd = '0;
    sel = '0;
    if (wr_lo_i) begin
      upd = {32'd0, wdata_i};
      sel = {32'd0, {WORD_W{1'b1}}};
    end
    if (wr_hi_i) begin
      upd = {wdata_i, 32'd0};
      sel = {{WORD_W{1'b1}}, 32'd0};
    end
    wen = sel & ~lock_i & VALID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) assoc_q <= '0;
    else         assoc_q <= (assoc_q & ~wen) | (upd & wen);
  end

  assign assoc_o = assoc_q;

  assert_locked_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i || wr_hi_i) |=> (((assoc_q ^ $past(assoc_q)) & $past(lock_i)) == '0));
  assert_no_write_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> $stable(assoc_q));
  assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (assoc_q & ~VALID) == '0);
endmodule

// File: rtl/md_lookup_mux.sv
module md_lookup_mux #(
  parameter int NUM_REQ = 8,
  parameter int NUM_MD  = 63,
  parameter int IDX_W   = 4
) (
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [NUM_REQ*NUM_MD-1:0] rows_i,
  output logic [NUM_MD-1:0]         md_o
);
  always_comb begin
    md_o = '0;
    for (int s = 0; s < NUM_REQ; s++)
      if (idx_i == IDX_W'(s)) md_o = rows_i[s*NUM_MD +: NUM_MD];
  end
endmodule

// File: rtl/md_assoc_lock.sv
module md_assoc_lock
  import md_lock_pkg::*;
#(
  parameter  int NUM_REQ = 8,
  parameter  int NUM_MD  = 63,
  parameter  bit LOCK_EN = 1'b1,
  localparam int IDX_W   = $clog2(NUM_REQ) + 1,
  localparam int ADDR_W  = $clog2(2*NUM_REQ + ENTRY_BASE) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic [IDX_W-1:0]  lookup_idx_i,
  output logic [NUM_MD-1:0] lookup_md_o
);
  localparam int END_A = ENTRY_BASE + 2*NUM_REQ;

  logic [MD_SPACE-1:0]       lock;
  logic [WORD_W-1:0]         lock_lo_rd, lock_hi_rd;
  logic [MD_SPACE-1:0]       assoc [NUM_REQ];
  logic [NUM_REQ*NUM_MD-1:0] rows_flat;

  md_lock_regs #(.NUM_MD(NUM_MD), .LOCK_EN(LOCK_EN)) u_locks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (reg_we_i && reg_addr_i == ADDR_W'(LOCK_LO_A)),
    .wr_hi_i (reg_we_i && reg_addr_i == ADDR_W'(LOCK_HI_A)),
    .wdata_i (reg_wdata_i),
    .lock_o  (lock),
    .rd_lo_o (lock_lo_rd),
    .rd_hi_o (lock_hi_rd)
  );

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_row
    md_assoc_row #(.NUM_MD(NUM_MD)) u_row (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (reg_we_i && reg_addr_i == ADDR_W'(ENTRY_BASE + 2*g)),
      .wr_hi_i (reg_we_i && reg_addr_i == ADDR_W'(ENTRY_BASE + 2*g + 1)),
      .wdata_i (reg_wdata_i),
      .lock_i  (lock),
      .assoc_o (assoc[g])
    );
    assign rows_flat[g*NUM_MD +: NUM_MD] = assoc[g][NUM_MD-1:0];
  end

  md_lookup_mux #(.NUM_REQ(NUM_REQ), .NUM_MD(NUM_MD), .IDX_W(IDX_W)) u_lookup (
    .idx_i  (lookup_idx_i),
    .rows_i (rows_flat),
    .md_o   (lookup_md_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(LOCK_LO_A)) reg_rdata_o = lock_lo_rd;
    if (reg_addr_i == ADDR_W'(LOCK_HI_A)) reg_rdata_o = lock_hi_rd;
    for (int s = 0; s < NUM_REQ; s++) begin
      if (reg_addr_i == ADDR_W'(ENTRY_BASE + 2*s))     reg_rdata_o = assoc[s][31:0];
      if (reg_addr_i == ADDR_W'(ENTRY_BASE + 2*s + 1)) reg_rdata_o = assoc[s][63:32];
    end
  end

  assert_lookup_oor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lookup_idx_i) >= NUM_REQ) |-> (lookup_md_o == '0));
  assert_unmapped_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(reg_addr_i) >= END_A) |-> (reg_rdata_o == '0));
  assert_lookup_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && $stable(lookup_idx_i)) |=> $stable(lookup_md_o));
endmodule

// File: tb/md_assoc_lock_test.sv
`timescale 1ns/1ps
module md_assoc_lock_test;
  localparam int NREQ = 8;
  localparam int NMD  = 63;
  localparam int AW   = 6;
  localparam int IW   = 4;
  localparam logic [63:0] VAL = 64'h7FFF_FFFF_FFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [IW-1:0] idx = '0;
  logic [31:0]   rdata, rdata_nl;
  logic [NMD-1:0] md, md_nl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_lock;
  logic        m_master;
  logic [63:0] m_assoc [NREQ];
  logic [63:0] n_assoc [NREQ];

  always #10 clk = ~clk;

  md_assoc_lock #(.NUM_REQ(NREQ), .NUM_MD(NMD), .LOCK_EN(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lookup_idx_i(idx), .lookup_md_o(md));

  md_assoc_lock #(.NUM_REQ(NREQ), .NUM_MD(NMD), .LOCK_EN(1'b0)) uut_nl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_nl), .lookup_idx_i(idx), .lookup_md_o(md_nl));

  function automatic logic [31:0] exp_rd(int a, bit nl);
    logic [63:0] v;
    if (a == 0) return nl ? 32'd0 : {m_lock[30:0], m_master};
    if (a == 1) return nl ? 32'd0 : m_lock[62:31];
    if (a >= 2 && a < 2 + 2*NREQ) begin
      v = nl ? n_assoc[(a-2)/2] : m_assoc[(a-2)/2];
      return (a % 2 == 0) ? v[31:0] : v[63:32];
    end
    return 32'd0;
  endfunction

  function automatic logic [NMD-1:0] exp_md(int i, bit nl);
    if (i >= NREQ) return '0;
    return nl ? n_assoc[i][NMD-1:0] : m_assoc[i][NMD-1:0];
  endfunction

  task automatic model_wr(int a, logic [31:0] d);
    logic [63:0] upd, sel;
    if (a == 0 && !m_master) begin
      m_lock   = m_lock | ({33'd0, d[31:1]} & VAL);
      m_master = m_master | d[0];
    end else if (a == 1 && !m_master) begin
      m_lock = m_lock | ({1'b0, d, 31'd0} & VAL);
    end else if (a >= 2 && a < 2 + 2*NREQ) begin
      upd = (a % 2 == 0) ? {32'd0, d} : {d, 32'd0};
      sel = (a % 2 == 0) ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_0000_0000;
      m_assoc[(a-2)/2] = (m_assoc[(a-2)/2] & ~(sel & ~m_lock & VAL)) | (upd & sel & ~m_lock & VAL);
      n_assoc[(a-2)/2] = (n_assoc[(a-2)/2] & ~(sel & VAL)) | (upd & sel & VAL);
    end
  endtask

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(string tag, int a);
    addr = AW'(a);
    #2;
    chk(tag, 64'(rdata), 64'(exp_rd(a, 1'b0)));
    chk({tag, " R9"}, 64'(rdata_nl), 64'(exp_rd(a, 1'b1)));
  endtask

  task automatic look(int i);
    idx = IW'(i);
    #2;
    chk("R7 lookup", 64'(md), 64'(exp_md(i, 1'b0)));
    chk("R7 R9 lookup", 64'(md_nl), 64'(exp_md(i, 1'b1)));
  endtask

  task automatic rand_phase(int n, bit allow_master);
    for (int k = 0; k < n; k++) begin
      int a;
      logic [31:0] d;
      a = $urandom_range(0, 2 + 2*NREQ + 1);
      if ($urandom_range(0, 15) == 0) a = 63;
      d = $urandom;
      if (a < 2) begin
        d = $urandom & $urandom & $urandom;
        if (!allow_master) d[0] = 1'b0;
      end
      wr(a, d);
      if (a < 2) rd("R3 R5 lock", a);
      else if (a < 2 + 2*NREQ) rd("R2 R4 entry", a);
      else rd("R8 unmapped", a);
      look($urandom_range(0, 15));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    m_lock = '0; m_master = 1'b0;
    for (int s = 0; s < NREQ; s++) begin m_assoc[s] = '0; n_assoc[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 2 + 2*NREQ; a++) rd("R1 reset", a);
    look(0); look(8); look(15);

    // R2 / R3 / R4 directed
    wr(2, 32'h0000_0020);  rd("R2 write lo", 2);
    wr(0, 32'h0000_0040);  rd("R3 lock md5", 0);
    wr(2, 32'h0000_0000);  rd("R4 md5 held", 2);
    wr(1, 32'h0000_0001);  rd("R3 lock md31", 1);
    wr(2, 32'hFFFF_FFFF);  rd("R4 md31 held", 2);
    wr(5, 32'hFFFF_FFFF);  rd("R2 hi bit31 zero", 5);
    look(0); look(1);

    // R5 writing zeros keeps locks
    wr(0, 32'h0);          rd("R5 lo zero write", 0);
    wr(1, 32'h0);          rd("R5 hi zero write", 1);

    // R8 unmapped write
    wr(2 + 2*NREQ, 32'hFFFF_FFFF); rd("R8 unmapped read", 2 + 2*NREQ);
    for (int a = 2; a < 2 + 2*NREQ; a++) rd("R8 table unchanged", a);

    rand_phase(300, 1'b0);

    // R6 master lock
    wr(0, 32'h0000_0001);  rd("R6 master set", 0);
    wr(1, 32'hFFFF_FFFF);  rd("R6 hi frozen", 1);
    wr(0, 32'hFFFF_FFFE);  rd("R6 lo frozen", 0);

    rand_phase(300, 1'b1);
    rd("R6 master still", 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule